// File: doc/BRIEF.md
# Next Instruction Pointer Unit

This block holds the instruction pointer of a processor core and works out the value it takes on the following clock edge. Each cycle in which an instruction retires (`step_i` high), the core gives the block the instruction's byte length, its decoded control-flow kind, the branch condition, a signed 32-bit displacement, an indirect target, the value just popped from the stack and a handler vector. The block then loads the pointer with the sequential address or with the target that the kind selects. While `step_i` is low the pointer holds its value.

Relative targets are measured from the end of the current instruction, that is from `ip_o + len_i`. The block also outputs the same sum as a pointer-relative effective address for data operands. Calls and interrupts raise a one-cycle push request that carries the address to save. A return raises a pop strobe in the same cycle in which it uses `pop_addr_i`. Instruction fetch, decode, the stack memory and the flag evaluation all sit outside the block.

Top module: `nip_unit`

## Requirements
- R1: During reset `ip_o` equals the parameter `RESET_VEC` and `push_valid_o` is 0. After reset the pointer changes only on a clock edge where `step_i` is 1, and holds otherwise.
- R2: On a step with kind 0 (sequential), the next pointer is `ip_o + len_i`, where `len_i` is zero-extended and ranges from 1 to 15. All address sums wrap modulo 2^64.
- R3: `rel_addr_o` is always `ip_o + len_i + sext(disp_i)`, where `disp_i` is a signed 32-bit value.
- R4: On a step with kind 1 (direct jump), the next pointer is the value on `rel_addr_o`.
- R5: On a step with kind 2 (conditional jump), the next pointer is `rel_addr_o` when `cond_i` is 1 and `ip_o + len_i` when `cond_i` is 0.
- R6: On a step with kind 3 (indirect jump), the next pointer is `ind_tgt_i`.
- R7: On a step with kind 4 (direct call) or kind 7 (indirect call), the next pointer is `rel_addr_o` or `ind_tgt_i` respectively. In the cycle after that edge, `push_valid_o` is 1 and `push_data_o` is the return address `ip_o + len_i` of the call.
- R8: On a step with kind 5 (return), `pop_o` is 1 in that cycle and the next pointer is `pop_addr_i`. `pop_o` is 0 in every other cycle.
- R9: On a step with kind 6 (interrupt), the next pointer is `vec_i`. In the cycle after that edge, `push_valid_o` is 1 and `push_data_o` is the pointer value from before the edge. `len_i` has no effect.
- R10: `push_valid_o` is 1 for exactly one cycle per call or interrupt step and is 0 after any other kind or a non-step cycle.
- R11: `next_ip_o` always shows the value that `ip_o` takes at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | An instruction retires this cycle |
| kind_i | input | 3 | Control-flow kind, 0 to 7 |
| len_i | input | 4 | Instruction length in bytes |
| cond_i | input | 1 | Branch condition for kind 2 |
| disp_i | input | 32 | Signed displacement |
| ind_tgt_i | input | 64 | Indirect jump or call target |
| pop_addr_i | input | 64 | Return address popped from the stack |
| vec_i | input | 64 | Interrupt handler address |
| ip_o | output | 64 | Current instruction pointer |
| next_ip_o | output | 64 | Pointer value after the coming edge |
| rel_addr_o | output | 64 | Pointer-relative effective address |
| pop_o | output | 1 | Stack pop strobe for a return |
| push_valid_o | output | 1 | Stack push request |
| push_data_o | output | 64 | Address to push |

## Verification
The checker tests the following on every cycle: the pointer holds when no step occurs, sequential stepping, loading from the popped value on return, the relation between `rel_addr_o` and the pointer, the qualification of the pop strobe, and the timing and content of a push after a call or interrupt. Some behaviour only the bench scenarios can show. This covers the taken and not-taken choice for conditional jumps, 64-bit wrap-around near the top of the address space, negative displacements, the handler and indirect targets, and a long random mix of kinds checked against a reference model.

// File: rtl/nip_pkg.sv
package nip_pkg;

   // Control-flow kinds carried on kind_i
   typedef enum logic [2:0] {
      CF_SEQ   = 3'd0,
      CF_JMP   = 3'd1,
      CF_JCC   = 3'd2,
      CF_JIND  = 3'd3,
      CF_CALL  = 3'd4,
      CF_RET   = 3'd5,
      CF_INT   = 3'd6,
      CF_CALLI = 3'd7
   } cf_kind_e;

   localparam int unsigned KIND_W = 3;

endpackage

// File: rtl/nip_addr_calc.sv
module nip_addr_calc #(
   parameter int unsigned AW = 64,
   parameter int unsigned DW = 32,
   parameter int unsigned LW = 4
) (
   input  logic [AW-1:0] ip_i,
   input  logic [LW-1:0] len_i,
   input  logic [DW-1:0] disp_i,
   output logic [AW-1:0] seq_o,
   output logic [AW-1:0] rel_o
);

   localparam int unsigned LEN_PAD  = AW - LW;
   localparam int unsigned DISP_PAD = AW - DW;

   logic [AW-1:0] len_ext;
   logic [AW-1:0] disp_ext;

   assign len_ext  = {{LEN_PAD{1'b0}}, len_i};
   assign disp_ext = {{DISP_PAD{disp_i[DW-1]}}, disp_i};

   // end of the current instruction, then relative offset from there
   assign seq_o = ip_i + len_ext;
   assign rel_o = seq_o + disp_ext;

endmodule

// File: rtl/nip_target_sel.sv
module nip_target_sel
   import nip_pkg::*;
#(
   parameter int unsigned AW = 64
) (
   input  logic                step_i,
   input  logic [KIND_W-1:0]   kind_i,
   input  logic                cond_i,
   input  logic [AW-1:0]       ip_i,
   input  logic [AW-1:0]       seq_i,
   input  logic [AW-1:0]       rel_i,
   input  logic [AW-1:0]       ind_i,
   input  logic [AW-1:0]       pop_i,
   input  logic [AW-1:0]       vec_i,
   output logic [AW-1:0]       next_o,
   output logic                push_req_o,
   output logic [AW-1:0]       push_val_o,
   output logic                pop_o
);

   cf_kind_e kind;
   assign kind = cf_kind_e'(kind_i);

   always_comb begin
      next_o     = ip_i;
      push_req_o = 1'b0;
      push_val_o = seq_i;
      pop_o      = 1'b0;
      if (step_i) begin
         unique case (kind)
            CF_SEQ:   next_o = seq_i;
            CF_JMP:   next_o = rel_i;
            CF_JCC:   next_o = cond_i ? rel_i : seq_i;
            CF_JIND:  next_o = ind_i;
            CF_CALL: begin
               next_o     = rel_i;
               push_req_o = 1'b1;
            end
            CF_CALLI: begin
               next_o     = ind_i;
               push_req_o = 1'b1;
            end
            CF_RET: begin
               next_o = pop_i;
               pop_o  = 1'b1;
            end
            CF_INT: begin
               next_o     = vec_i;
               push_req_o = 1'b1;
               push_val_o = ip_i;
            end
            default:  next_o = seq_i;
         endcase
      end
   end

endmodule

// File: rtl/nip_push_stage.sv
module nip_push_stage #(
   parameter int unsigned AW       = 64,
   parameter bit          REG_PUSH = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          req_i,
   input  logic [AW-1:0] data_i,
   output logic          valid_o,
   output logic [AW-1:0] data_o
);

   generate
      if (REG_PUSH) begin : g_reg
         logic          vld_q;
         logic [AW-1:0] dat_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               vld_q <= 1'b0;
               dat_q <= '0;
            end else begin
               vld_q <= req_i;
               if (req_i) dat_q <= data_i;
            end
         end
         assign valid_o = vld_q;
         assign data_o  = dat_q;
      end else begin : g_comb
         assign valid_o = req_i & rst_ni;
         assign data_o  = data_i;
      end
   endgenerate

endmodule

// File: rtl/nip_unit.sv
module nip_unit
   import nip_pkg::*;
#(
   parameter int unsigned AW        = 64,
   parameter int unsigned DW        = 32,
   parameter int unsigned LW        = 4,
   parameter logic [63:0] RESET_VEC = 64'h0000_0000_0000_1000,
   parameter bit          REG_PUSH  = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                step_i,
   input  logic [KIND_W-1:0]   kind_i,
   input  logic [LW-1:0]       len_i,
   input  logic                cond_i,
   input  logic [DW-1:0]       disp_i,
   input  logic [AW-1:0]       ind_tgt_i,
   input  logic [AW-1:0]       pop_addr_i,
   input  logic [AW-1:0]       vec_i,
   output logic [AW-1:0]       ip_o,
   output logic [AW-1:0]       next_ip_o,
   output logic [AW-1:0]       rel_addr_o,
   output logic                pop_o,
   output logic                push_valid_o,
   output logic [AW-1:0]       push_data_o
);

   localparam logic [AW-1:0] RST_IP = RESET_VEC[AW-1:0];

   generate
      if (AW <= DW) begin : g_chk_aw
         $error("nip_unit: AW must exceed DW");
      end
      if (LW < 4) begin : g_chk_lw
         $error("nip_unit: LW must hold lengths up to 15");
      end
      if (AW > 64) begin : g_chk_max
         $error("nip_unit: AW is limited to 64");
      end
   endgenerate

   logic [AW-1:0] ip_q;
   logic [AW-1:0] seq_addr;
   logic [AW-1:0] rel_addr;
   logic [AW-1:0] next_ip;
   logic          push_req;
   logic [AW-1:0] push_val;

   nip_addr_calc #(.AW(AW), .DW(DW), .LW(LW)) i_calc (
      .ip_i   (ip_q),
      .len_i  (len_i),
      .disp_i (disp_i),
      .seq_o  (seq_addr),
      .rel_o  (rel_addr)
   );

   nip_target_sel #(.AW(AW)) i_sel (
      .step_i     (step_i),
      .kind_i     (kind_i),
      .cond_i     (cond_i),
      .ip_i       (ip_q),
      .seq_i      (seq_addr),
      .rel_i      (rel_addr),
      .ind_i      (ind_tgt_i),
      .pop_i      (pop_addr_i),
      .vec_i      (vec_i),
      .next_o     (next_ip),
      .push_req_o (push_req),
      .push_val_o (push_val),
      .pop_o      (pop_o)
   );

   nip_push_stage #(.AW(AW), .REG_PUSH(REG_PUSH)) i_push (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (push_req),
      .data_i  (push_val),
      .valid_o (push_valid_o),
      .data_o  (push_data_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) ip_q <= RST_IP;
      else         ip_q <= next_ip;
   end

   assign ip_o       = ip_q;
   assign next_ip_o  = rst_ni ? next_ip : RST_IP;
   assign rel_addr_o = rel_addr;

endmodule

// File: rtl/nip_unit_chk.sv
module nip_unit_chk #(
   parameter int unsigned AW        = 64,
   parameter int unsigned DW        = 32,
   parameter int unsigned LW        = 4,
   parameter logic [63:0] RESET_VEC = 64'h0000_0000_0000_1000,
   parameter bit          REG_PUSH  = 1'b1
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          step_i,
   input logic [2:0]    kind_i,
   input logic [LW-1:0] len_i,
   input logic          cond_i,
   input logic [DW-1:0] disp_i,
   input logic [AW-1:0] ind_tgt_i,
   input logic [AW-1:0] pop_addr_i,
   input logic [AW-1:0] vec_i,
   input logic [AW-1:0] ip_o,
   input logic [AW-1:0] next_ip_o,
   input logic [AW-1:0] rel_addr_o,
   input logic          pop_o,
   input logic          push_valid_o,
   input logic [AW-1:0] push_data_o
);

   logic          up_q;
   logic [AW-1:0] end_c;
   logic [AW-1:0] rel_diff;
   logic [AW-1:0] disp_ext;
   logic          push_kind;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) up_q <= 1'b0;
      else         up_q <= 1'b1;
   end

   assign end_c     = ip_o + {{(AW-LW){1'b0}}, len_i};
   assign rel_diff  = rel_addr_o - end_c;
   assign disp_ext  = {{(AW-DW){disp_i[DW-1]}}, disp_i};
   assign push_kind = step_i && (kind_i == 3'd4 || kind_i == 3'd6 || kind_i == 3'd7);

   // R1
   hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_q && !step_i) |=> ip_o == $past(ip_o));

   // R2
   seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_q && step_i && kind_i == 3'd0) |=> ip_o == $past(end_c));

   // R3
   rel_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_diff == disp_ext);

   // R8
   ret_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_q && step_i && kind_i == 3'd5) |=> ip_o == $past(pop_addr_i));

   // R8
   pop_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_o |-> (step_i && kind_i == 3'd5));

   // R11
   next_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      up_q |=> ip_o == $past(next_ip_o));

   generate
      if (REG_PUSH) begin : g_push_chk
         // R10
         push_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            up_q |=> push_valid_o == $past(push_kind));

         // R7
         call_push_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (up_q && step_i && (kind_i == 3'd4 || kind_i == 3'd7)) |=> push_data_o == $past(end_c));

         // R9
         int_push_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (up_q && step_i && kind_i == 3'd6) |=> push_data_o == $past(ip_o));
      end
   endgenerate

endmodule

bind nip_unit nip_unit_chk #(
   .AW(AW), .DW(DW), .LW(LW), .RESET_VEC(RESET_VEC), .REG_PUSH(REG_PUSH)
) i_nip_unit_chk (.*);

// File: tb/test_nip_unit.sv
module test_nip_unit;

   localparam logic [63:0] RV = 64'h0000_0000_0000_1000;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        step_i = 1'b0;
   logic [2:0]  kind_i = '0;
   logic [3:0]  len_i = 4'd1;
   logic        cond_i = 1'b0;
   logic [31:0] disp_i = '0;
   logic [63:0] ind_tgt_i = '0;
   logic [63:0] pop_addr_i = '0;
   logic [63:0] vec_i = '0;
   logic [63:0] ip_o, next_ip_o, rel_addr_o, push_data_o;
   logic        pop_o, push_valid_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [63:0] m_ip;

   always #5 clk_i = ~clk_i;

   nip_unit #(.RESET_VEC(RV)) i_nip_unit (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .kind_i(kind_i),
      .len_i(len_i), .cond_i(cond_i), .disp_i(disp_i), .ind_tgt_i(ind_tgt_i),
      .pop_addr_i(pop_addr_i), .vec_i(vec_i), .ip_o(ip_o), .next_ip_o(next_ip_o),
      .rel_addr_o(rel_addr_o), .pop_o(pop_o), .push_valid_o(push_valid_o),
      .push_data_o(push_data_o)
   );

   always @(posedge clk_i) begin
      cyc <= cyc + 1;
      if (cyc > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] f_end(input logic [63:0] ip, input logic [3:0] l);
      return ip + {60'd0, l};
   endfunction

   function automatic logic [63:0] f_rel(input logic [63:0] ip, input logic [3:0] l,
                                         input logic [31:0] d);
      return f_end(ip, l) + {{32{d[31]}}, d};
   endfunction

   function automatic logic [63:0] f_next(input logic [63:0] ip, input logic s,
         input logic [2:0] k, input logic [3:0] l, input logic c, input logic [31:0] d,
         input logic [63:0] it, input logic [63:0] pa, input logic [63:0] v);
      if (!s) return ip;
      case (k)
         3'd0: return f_end(ip, l);
         3'd1: return f_rel(ip, l, d);
         3'd2: return c ? f_rel(ip, l, d) : f_end(ip, l);
         3'd3: return it;
         3'd4: return f_rel(ip, l, d);
         3'd5: return pa;
         3'd6: return v;
         default: return it;
      endcase
   endfunction

   function automatic string f_req(input logic s, input logic [2:0] k);
      if (!s) return "R1";
      case (k)
         3'd0: return "R2";
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R6";
         3'd5: return "R8";
         3'd6: return "R9";
         default: return "R7";
      endcase
   endfunction

   // one cycle: drive at negedge, check combinational outputs, then registered ones
   task automatic run(input logic s, input logic [2:0] k, input logic [3:0] l,
                      input logic c, input logic [31:0] d, input logic [63:0] it,
                      input logic [63:0] pa, input logic [63:0] v);
      logic [63:0] exp_nx, exp_pd;
      logic        exp_pv;
      step_i = s; kind_i = k; len_i = l; cond_i = c; disp_i = d;
      ind_tgt_i = it; pop_addr_i = pa; vec_i = v;
      #1;
      exp_nx = f_next(m_ip, s, k, l, c, d, it, pa, v);
      chk("R3 rel_addr", rel_addr_o, f_rel(m_ip, l, d));
      chk("R11 next_ip", next_ip_o, exp_nx);
      chk("R8 pop strobe", {63'd0, pop_o}, {63'd0, (s && k == 3'd5)});
      exp_pv = s && (k == 3'd4 || k == 3'd6 || k == 3'd7);
      exp_pd = (k == 3'd6) ? m_ip : f_end(m_ip, l);
      @(negedge clk_i);
      chk(f_req(s, k), ip_o, exp_nx);
      chk("R10 push valid", {63'd0, push_valid_o}, {63'd0, exp_pv});
      if (exp_pv) chk(k == 3'd6 ? "R9 push data" : "R7 push data", push_data_o, exp_pd);
      m_ip = exp_nx;
   endtask

   initial begin
      void'($urandom(32'd4242));
      m_ip = RV;
      repeat (3) @(negedge clk_i);
      chk("R1 reset ip", ip_o, RV);
      chk("R1 reset push", {63'd0, push_valid_o}, 64'd0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk("R1 ip after reset", ip_o, RV);

      // directed corner cases
      run(1'b1, 3'd0, 4'd15, 1'b0, 32'd0, '0, '0, '0);                     // R2 max length
      run(1'b0, 3'd3, 4'd5, 1'b1, 32'd7, 64'hDEAD, 64'hBEEF, 64'hCAFE);    // R1 idle hold
      run(1'b1, 3'd2, 4'd2, 1'b0, 32'h40, '0, '0, '0);                     // R5 not taken
      run(1'b1, 3'd2, 4'd2, 1'b1, 32'h40, '0, '0, '0);                     // R5 taken
      run(1'b1, 3'd1, 4'd3, 1'b0, 32'h8000_0000, '0, '0, '0);              // R4 negative disp
      run(1'b1, 3'd3, 4'd1, 1'b0, 32'd0, 64'hFFFF_FFFF_FFFF_FFFE, '0, '0); // R6
      run(1'b1, 3'd0, 4'd5, 1'b0, 32'd0, '0, '0, '0);                      // R2 wrap
      run(1'b1, 3'd4, 4'd5, 1'b0, 32'h100, '0, '0, '0);                    // R7 direct call
      run(1'b1, 3'd7, 4'd2, 1'b0, 32'd0, 64'h0000_7000_0000_0010, '0, '0); // R7 indirect call
      run(1'b1, 3'd6, 4'd9, 1'b0, 32'd0, '0, '0, 64'hFFFF_8000_0000_0400); // R9 interrupt
      run(1'b1, 3'd6, 4'd1, 1'b0, 32'd0, '0, '0, 64'h0000_0000_0000_0800); // R9 back to back
      run(1'b1, 3'd5, 4'd1, 1'b0, 32'd0, '0, 64'h0000_1234_5678_9ABC, '0); // R8 return
      run(1'b1, 3'd0, 4'd1, 1'b0, 32'd0, '0, '0, '0);                      // R10 push drops

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] l;
         l = 4'(1 + ($urandom % 15));
         run(($urandom % 8) != 0, 3'($urandom % 8), l, 1'($urandom % 2), $urandom,
             {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule